// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM alive by issuing CAS-before-RAS (CBR) refresh cycles. After reset it waits out the power-up pause and then fires a burst of initialisation refreshes. In normal operation it issues one refresh for every tick of a free-running interval timer. It shares the DRAM control strobes with the access controller. It raises `busReq` whenever it has work, and it starts a cycle only in a cycle where `busGnt` is high. While it owns the bus it drives RAS, CAS and WE. No address is produced, because a CBR refresh takes its row from the counter inside the DRAM.

Timer ticks that arrive while the grant is withheld are not lost. They are kept as owed refreshes, up to a small cap, and are paid back in a back-to-back burst once the grant returns. The block also supports low-power self refresh. While `selfRefReq` is high, it brackets a long CBR cycle with ordinary refreshes on both sides. It keeps RAS low long enough that the DRAM really enters self refresh. After exit it applies the longer precharge. It refuses a new entry until a full set of row refreshes has completed since the last exit.

All timing is given in clock cycles through parameters. The defaults assume a 100 MHz clock: a 200 µs pause, a 15.6 µs interval and 4096 rows.

Top module: `refresh_sched`

## Requirements
- R1: While `rstN` is low, `rasN`, `casN` and `weN` are 1, and `busReq`, `initDone` and `selfRefActive` are 0.
- R2: After reset the block keeps `busReq` low and the strobes idle for INIT_WAIT cycles. It then performs exactly INIT_CYCLES CBR refreshes. `initDone` rises only after the last of them has finished its precharge. Self refresh is never active before `initDone`.
- R3: In every CBR cycle, `casN` goes low exactly CSR_CYC cycles before `rasN` falls. In an ordinary cycle it stays low for exactly CHR_CYC cycles of the RAS-low time. `weN` is 1 at all times.
- R4: An ordinary refresh holds `rasN` low for exactly RAS_CYC cycles. It is followed by at least RP_CYC cycles with `rasN` high.
- R5: Once `initDone` is high and the grant is held high, successive refreshes start exactly INTERVAL cycles apart.
- R6: The interval timer keeps running while the grant is withheld. Each tick adds one owed refresh, up to OWE_MAX, and further ticks are dropped. When the grant returns, the owed refreshes run back to back, and the timer phase is unchanged.
- R7: `rasN` and `casN` are driven low only while `busReq` is high. A cycle starts only after `busGnt` has been sampled high with `busReq` high.
- R8: A self-refresh request first causes an ordinary refresh. The next cycle is a self-refresh CBR, which starts 13 cycles after it with the default widths. `selfRefActive` is high while that cycle holds RAS low. RAS stays low for at least SR_MIN_CYC cycles even if the request drops earlier. RAS-low times lie either at RAS_CYC or at SR_MIN_CYC and above, never in between.
- R9: After self-refresh exit, `rasN` stays high for SR_RP_CYC cycles of precharge, then one idle cycle and the CAS lead (15 cycles with the defaults). An ordinary refresh follows at once. The interval timer restarts from zero at the end of that precharge, so the next timed refresh starts INTERVAL cycles after the post-exit refresh.
- R10: After an exit, self refresh cannot be entered again until ROWS ordinary refreshes have completed since that exit. The post-exit refresh counts as one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busGnt | input | 1 | Access controller hands the DRAM strobes to this block |
| selfRefReq | input | 1 | Level request to hold the DRAM in self refresh |
| busReq | output | 1 | Request for ownership of the DRAM strobes, high for the whole refresh |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low, held high |
| initDone | output | 1 | Power-up sequence complete, normal access allowed |
| selfRefActive | output | 1 | DRAM is being held in self refresh |

## Verification
The riskiest corner is the owed-refresh queue. The bench withholds the grant across two and then five timer ticks, and it expects exactly two and then exactly three burst refreshes. It then checks that the next timed refresh lands on the original timer phase. A design that restarted the timer, dropped ticks or failed to saturate would show a wrong burst count or a shifted refresh. Self refresh is tested with a request that drops early. A design that released RAS when the request fell would give a RAS-low time in the forbidden window. The bench also checks the long precharge after exit, the refresh that follows immediately, and the timer restart. A design that allowed immediate re-entry would show `selfRefActive` before three timed refreshes had passed.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [2:0] {
    S_PAUSE,
    S_IDLE,
    S_CAS,
    S_RAS,
    S_PRE
  } rsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseClr;      // restart the phase counter
    logic timerRun;      // interval timer advances
    logic timerRestart;  // interval timer back to zero
    logic rowInc;        // one ordinary refresh completed
    logic rowClr;        // self refresh just ended
  } rsStrobe_t;

endpackage

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int INIT_WAIT = 20000,
  parameter int INTERVAL  = 1560,
  parameter int ROWS      = 4096,
  parameter int PHASE_W   = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  rsStrobe_t          strobe,
  output logic               initWaitDone,
  output logic               intervalHit,
  output logic [PHASE_W-1:0] phaseCnt,
  output logic               rowsFull
);

  localparam int INIT_W = $clog2(INIT_WAIT + 1);
  localparam int IV_W   = $clog2(INTERVAL);
  localparam int ROW_W  = $clog2(ROWS + 1);

  logic [INIT_W-1:0] initCnt;
  logic [IV_W-1:0]   intervalCnt;
  logic [ROW_W-1:0]  rowCnt;

  assign initWaitDone = (initCnt == INIT_W'(INIT_WAIT));
  assign intervalHit  = strobe.timerRun && (intervalCnt == IV_W'(INTERVAL - 1));
  assign rowsFull     = (rowCnt == ROW_W'(ROWS));

  // power-up pause counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              initCnt <= '0;
    else if (!initWaitDone) initCnt <= initCnt + 1'b1;
  end

  // free-running interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    intervalCnt <= '0;
    else if (strobe.timerRestart) intervalCnt <= '0;
    else if (intervalHit)         intervalCnt <= '0;
    else if (strobe.timerRun)     intervalCnt <= intervalCnt + 1'b1;
  end

  // per-state phase counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strobe.phaseClr)  phaseCnt <= '0;
    else if (phaseCnt != '1)   phaseCnt <= phaseCnt + 1'b1;
  end

  // ordinary refreshes since reset or last self-refresh exit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         rowCnt <= '0;
    else if (strobe.rowClr)            rowCnt <= '0;
    else if (strobe.rowInc && !rowsFull) rowCnt <= rowCnt + 1'b1;
  end

  // R5: the timer never passes its terminal count
  p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    intervalCnt <= IV_W'(INTERVAL - 1));

endmodule

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
#(
  parameter int INIT_CYCLES = 8,
  parameter int CSR_CYC     = 1,
  parameter int CHR_CYC     = 2,
  parameter int RAS_CYC     = 6,
  parameter int RP_CYC      = 5,
  parameter int SR_MIN_CYC  = 10010,
  parameter int SR_RP_CYC   = 13,
  parameter int OWE_MAX     = 4,
  parameter int PHASE_W     = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busGnt,
  input  logic               selfRefReq,
  input  logic               initWaitDone,
  input  logic               intervalHit,
  input  logic               rowsFull,
  input  logic [PHASE_W-1:0] phaseCnt,
  output rsStrobe_t          strobe,
  output logic               busReq,
  output logic               rasN,
  output logic               casN,
  output logic               weN,
  output logic               initDone,
  output logic               selfRefActive
);

  localparam int IL_W = $clog2(INIT_CYCLES + 1);
  localparam int OW_W = $clog2(OWE_MAX + 1);

  rsState_e          state, nextState;
  logic [IL_W-1:0]   initLeft;
  logic [OW_W-1:0]   owed;
  logic              selfKind, needPost, srArmed;
  logic              mustNormal, pendSelf, wantPre, pending;
  logic              startCyc, owedTake, owedAdd, preDone;

  always_comb begin
    mustNormal = (initLeft != '0) || needPost || (owed != '0);
    pendSelf   = srArmed && selfRefReq;
    wantPre    = initDone && selfRefReq && rowsFull && !srArmed;
    pending    = mustNormal || pendSelf || wantPre;
    startCyc   = (state == S_IDLE) && pending && busGnt;
    owedTake   = startCyc && (initLeft == '0) && !needPost && (owed != '0);
    owedAdd    = intervalHit && ((owed != OW_W'(OWE_MAX)) || owedTake);

    nextState = state;
    unique case (state)
      S_PAUSE: if (initWaitDone) nextState = S_IDLE;
      S_IDLE:  if (startCyc) nextState = S_CAS;
      S_CAS:   if (phaseCnt == PHASE_W'(CSR_CYC - 1)) nextState = S_RAS;
      S_RAS: begin
        if (selfKind) begin
          if (!selfRefReq && (phaseCnt >= PHASE_W'(SR_MIN_CYC - 1))) nextState = S_PRE;
        end else if (phaseCnt == PHASE_W'(RAS_CYC - 1)) begin
          nextState = S_PRE;
        end
      end
      S_PRE: begin
        if (phaseCnt == (selfKind ? PHASE_W'(SR_RP_CYC - 1) : PHASE_W'(RP_CYC - 1)))
          nextState = S_IDLE;
      end
      default: nextState = S_PAUSE;
    endcase
    preDone = (state == S_PRE) && (nextState == S_IDLE);

    strobe.phaseClr     = (nextState != state);
    strobe.timerRun     = initDone && !selfKind;
    strobe.timerRestart = preDone && selfKind;
    strobe.rowInc       = preDone && !selfKind;
    strobe.rowClr       = preDone && selfKind;

    busReq        = (state == S_IDLE) ? pending : (state != S_PAUSE);
    rasN          = (state != S_RAS);
    casN          = !((state == S_CAS) ||
                      ((state == S_RAS) && (selfKind || (phaseCnt < PHASE_W'(CHR_CYC)))));
    weN           = 1'b1;
    selfRefActive = (state == S_RAS) && selfKind;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_PAUSE;
      initLeft <= IL_W'(INIT_CYCLES);
      owed     <= '0;
      selfKind <= 1'b0;
      needPost <= 1'b0;
      srArmed  <= 1'b0;
      initDone <= 1'b0;
    end else begin
      state <= nextState;

      if (startCyc)     selfKind <= !mustNormal && pendSelf;
      else if (preDone) selfKind <= 1'b0;

      if (preDone && selfKind) needPost <= 1'b1;
      else if (startCyc && (initLeft == '0)) needPost <= 1'b0;

      if (startCyc && !mustNormal)                 srArmed <= !pendSelf;
      else if ((state == S_IDLE) && !selfRefReq)   srArmed <= 1'b0;

      if (preDone && !selfKind && (initLeft != '0)) begin
        initLeft <= initLeft - 1'b1;
        if (initLeft == IL_W'(1)) initDone <= 1'b1;
      end

      if (owedAdd && !owedTake)      owed <= owed + 1'b1;
      else if (!owedAdd && owedTake) owed <= owed - 1'b1;
    end
  end

  // R3: CAS is already low in the cycle before RAS falls and as RAS falls
  p_cas_leads_ras_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && !$past(casN)));

  // R7: a cycle begins only after a sampled grant
  p_grant_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CAS && $past(state) == S_IDLE) |-> $past(busGnt));

  // R6: the owed count never exceeds its cap
  p_owed_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    owed <= OW_W'(OWE_MAX));

  // R8: RAS-low time is either the ordinary width or the self-refresh minimum
  p_low_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (($past(phaseCnt) == PHASE_W'(RAS_CYC - 1)) ||
                     ($past(phaseCnt) >= PHASE_W'(SR_MIN_CYC - 1))));

  // R2: no self refresh before the power-up sequence is finished
  p_init_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !selfRefActive);

  // R10: entry only with a full set of rows refreshed since the last exit
  p_reentry_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfRefActive) |-> rowsFull);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int INIT_WAIT   = 20000,
  parameter int INIT_CYCLES = 8,
  parameter int INTERVAL    = 1560,
  parameter int ROWS        = 4096,
  parameter int OWE_MAX     = 4,
  parameter int CSR_CYC     = 1,
  parameter int CHR_CYC     = 2,
  parameter int RAS_CYC     = 6,
  parameter int RP_CYC      = 5,
  parameter int SR_MIN_CYC  = 10010,
  parameter int SR_RP_CYC   = 13
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGnt,
  input  logic selfRefReq,
  output logic busReq,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic initDone,
  output logic selfRefActive
);

  localparam int PHASE_W = $clog2(SR_MIN_CYC + SR_RP_CYC + RAS_CYC + 1);

  rsStrobe_t          strobe;
  logic               initWaitDone, intervalHit, rowsFull;
  logic [PHASE_W-1:0] phaseCnt;

  refresh_sched_dp #(
    .INIT_WAIT (INIT_WAIT),
    .INTERVAL  (INTERVAL),
    .ROWS      (ROWS),
    .PHASE_W   (PHASE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .initWaitDone (initWaitDone),
    .intervalHit  (intervalHit),
    .phaseCnt     (phaseCnt),
    .rowsFull     (rowsFull)
  );

  refresh_sched_ctrl #(
    .INIT_CYCLES (INIT_CYCLES),
    .CSR_CYC     (CSR_CYC),
    .CHR_CYC     (CHR_CYC),
    .RAS_CYC     (RAS_CYC),
    .RP_CYC      (RP_CYC),
    .SR_MIN_CYC  (SR_MIN_CYC),
    .SR_RP_CYC   (SR_RP_CYC),
    .OWE_MAX     (OWE_MAX),
    .PHASE_W     (PHASE_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .busGnt        (busGnt),
    .selfRefReq    (selfRefReq),
    .initWaitDone  (initWaitDone),
    .intervalHit   (intervalHit),
    .rowsFull      (rowsFull),
    .phaseCnt      (phaseCnt),
    .strobe        (strobe),
    .busReq        (busReq),
    .rasN          (rasN),
    .casN          (casN),
    .weN           (weN),
    .initDone      (initDone),
    .selfRefActive (selfRefActive)
  );

endmodule

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;

  localparam int INIT_WAIT = 50;
  localparam int INIT_CYC  = 8;
  localparam int INTERVAL  = 100;
  localparam int ROWS      = 4;
  localparam int OWE_MAX   = 3;
  localparam int CSR       = 1;
  localparam int CHR       = 2;
  localparam int RASC      = 6;
  localparam int RPC       = 5;
  localparam int SRMIN     = 40;
  localparam int SRRP      = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busGnt = 1'b1;
  logic selfRefReq = 1'b0;
  logic busReq, rasN, casN, weN, initDone, selfRefActive;

  always #5 clk = ~clk;

  refresh_sched #(
    .INIT_WAIT(INIT_WAIT), .INIT_CYCLES(INIT_CYC), .INTERVAL(INTERVAL), .ROWS(ROWS),
    .OWE_MAX(OWE_MAX), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASC), .RP_CYC(RPC),
    .SR_MIN_CYC(SRMIN), .SR_RP_CYC(SRRP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busGnt(busGnt), .selfRefReq(selfRefReq),
    .busReq(busReq), .rasN(rasN), .casN(casN), .weN(weN),
    .initDone(initDone), .selfRefActive(selfRefActive)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // waveform monitor, updated on the falling clock edge
  bit live = 1'b0;
  bit prevRas = 1'b1;
  bit srSeen = 1'b0;
  int fallCount = 0, lastFall = 0, prevFall = 0;
  int lowRun = 0, highRun = 0, leadRun = 0, holdRun = 0;
  int lastLowLen = 0, lastHighLen = 0, lastLead = 0, lastHold = 0;
  int errWe = 0, errLead = 0, errLen = 0, errReq = 0;

  always @(negedge clk) begin
    if (live) begin
      if (weN !== 1'b1) errWe++;
      if ((!rasN || !casN) && !busReq) errReq++;
      if (selfRefActive) srSeen = 1'b1;
      if (prevRas && !rasN) begin
        prevFall = lastFall;
        lastFall = cyc;
        fallCount++;
        lastHighLen = highRun;
        lastLead = leadRun;
        if (leadRun != CSR) errLead++;
        lowRun = 1;
        holdRun = casN ? 0 : 1;
      end else if (!rasN) begin
        lowRun++;
        if (!casN) holdRun++;
      end
      if (!prevRas && rasN) begin
        lastLowLen = lowRun;
        lastHold = holdRun;
        if (lowRun < SRMIN && (lowRun != RASC || holdRun != CHR)) errLen++;
        highRun = 1;
      end else if (rasN) begin
        highRun++;
      end
      if (rasN && !casN) leadRun++;
      else if (rasN) leadRun = 0;
      prevRas = rasN;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic tickTo(input int target);
    while (cyc < target) tick();
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitFall();
    int base = fallCount;
    int n = 0;
    while (fallCount == base && n < 3000) begin
      tick();
      n++;
    end
    check(fallCount != base, "waitFall RAS activity", fallCount, base + 1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) tick();
    check(rasN == 1'b1, "R1 rasN", rasN, 1);
    check(casN == 1'b1, "R1 casN", casN, 1);
    check(weN == 1'b1, "R1 weN", weN, 1);
    check(busReq == 1'b0, "R1 busReq", busReq, 0);
    check(initDone == 1'b0, "R1 initDone", initDone, 0);
    check(selfRefActive == 1'b0, "R1 selfRefActive", selfRefActive, 0);
  endtask

  task automatic testInit();
    int rel;
    int quietBad = 0;
    int n = 0;
    int firstFall = -1;
    rstN = 1'b1;
    live = 1'b1;
    rel = cyc;
    for (int i = 0; i < INIT_WAIT - 1; i++) begin
      tick();
      if (busReq || !rasN || !casN) quietBad++;
    end
    check(quietBad == 0, "R2 quiet during pause", quietBad, 0);
    while (!initDone && n < 1000) begin
      tick();
      if (fallCount == 1 && firstFall < 0) firstFall = cyc;
      n++;
    end
    check(firstFall - rel >= INIT_WAIT, "R2 first refresh after pause", firstFall - rel, INIT_WAIT);
    check(fallCount == INIT_CYC, "R2 init refresh count", fallCount, INIT_CYC);
    check(selfRefActive == 1'b0, "R2 no self refresh", selfRefActive, 0);
  endtask

  task automatic testWaveAndInterval();
    waitFall();
    waitFall();
    check(lastFall - prevFall == INTERVAL, "R5 refresh spacing", lastFall - prevFall, INTERVAL);
    check(lastLead == CSR, "R3 CAS lead", lastLead, CSR);
    check(lastHighLen >= RPC, "R4 precharge", lastHighLen, RPC);
    tickTo(lastFall + RASC + 2);
    check(lastLowLen == RASC, "R4 RAS low width", lastLowLen, RASC);
    check(lastHold == CHR, "R3 CAS hold", lastHold, CHR);
    check(errWe == 0, "R3 weN high", errWe, 0);
  endtask

  task automatic testQueue();
    int f;
    int base;
    waitFall();
    f = lastFall;
    tickTo(f + 20);
    busGnt = 1'b0;
    base = fallCount;
    tickTo(f + 270);
    check(fallCount == base, "R7 no refresh without grant", fallCount - base, 0);
    busGnt = 1'b1;
    tickTo(f + 295);
    check(fallCount - base == 2, "R6 owed burst of two", fallCount - base, 2);
    waitFall();
    check(lastFall == f + 300, "R6 timer phase kept", lastFall - f, 300);
    f = lastFall;
    tickTo(f + 20);
    busGnt = 1'b0;
    base = fallCount;
    tickTo(f + 520);
    busGnt = 1'b1;
    tickTo(f + 590);
    check(fallCount - base == OWE_MAX, "R6 owed saturates", fallCount - base, OWE_MAX);
    waitFall();
    check(lastFall == f + 600, "R6 timer phase after saturation", lastFall - f, 600);
    check(errReq == 0, "R7 strobes only with busReq", errReq, 0);
  endtask

  task automatic testSelf(output int postFall);
    int f;
    int preF;
    waitFall();
    f = lastFall;
    tickTo(f + 30);
    selfRefReq = 1'b1;
    waitFall();
    preF = lastFall;
    waitFall();
    check(lastFall - preF <= RASC + RPC + CSR + 2, "R8 refresh right before entry", lastFall - preF, 13);
    tickTo(lastFall + 10);
    check(selfRefActive == 1'b1, "R8 selfRefActive", selfRefActive, 1);
    selfRefReq = 1'b0;
    while (!rasN) tick();
    check(lastLowLen == SRMIN, "R8 minimum self-refresh hold", lastLowLen, SRMIN);
    waitFall();
    check(lastHighLen == SRRP + 2, "R9 long precharge then refresh", lastHighLen, SRRP + 2);
    check(selfRefActive == 1'b0, "R9 self refresh left", selfRefActive, 0);
    postFall = lastFall;
  endtask

  task automatic testReentry(input int p);
    int base;
    tickTo(p + 5);
    srSeen = 1'b0;
    selfRefReq = 1'b1;
    base = fallCount;
    waitFall();
    check(lastFall - p == INTERVAL, "R9 timer restarted", lastFall - p, INTERVAL);
    tickTo(p + 305);
    check(srSeen == 1'b0, "R10 entry blocked", srSeen, 0);
    check(fallCount - base == 3, "R10 ordinary refreshes before entry", fallCount - base, 3);
    tickTo(p + 330);
    check(selfRefActive == 1'b1, "R10 entry after full row set", selfRefActive, 1);
    selfRefReq = 1'b0;
    while (!rasN) tick();
    waitFall();
    tickTo(lastFall + RASC + 2);
    check(errLen == 0, "R8 RAS low window", errLen, 0);
    check(errLead == 0, "R3 CAS lead every cycle", errLead, 0);
  endtask

  initial begin
    int post;
    testReset();
    testInit();
    testWaveAndInterval();
    testQueue();
    testSelf(post);
    testReentry(post);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule